// File: doc/BRIEF.md
# Programming Address Counter and Mapper

This block keeps the word pointer that a serial program/verify engine steps through while a device is being programmed. It also turns that pointer into the addresses that the physical stores see. A command decoder drives three strobes, each one clock long. The first is a synchronous clear, issued on mode entry or exit. The second jumps the pointer to the base of configuration space. The third advances the pointer by one.

The pointer has fourteen bits. The lower half of its range is user program space and the upper half is configuration space. Once the pointer enters the upper half it cannot leave it: stepping past the top of the range lands back on the configuration base, not on zero. Only a clear returns the pointer to user space.

The mapper registers all decode outputs. They are computed from the pointer's next value, so they change on the same clock edge as the pointer. The outputs are:
- a 1K-word program address;
- a flag that selects the small configuration store;
- the word index within that store;
- hits for the identification words and the configuration word;
- a 64-byte data-store address.

Top module: `pgm_addr_mapper`

## Requirements
- R1: After reset, and in the cycle after `mode_clr` is sampled high, `addr_q` is 0x0000 and every decode output is zero.
- R2: An `incr` strobe adds one to `addr_q`. Stepping from 0x1FFF gives 0x2000.
- R3: An `incr` strobe at 0x3FFF gives 0x2000. While bit 13 of `addr_q` is 1, it stays 1 until a clear.
- R4: `load_cfg` sets `addr_q` to 0x2000. Strobe priority is `mode_clr` first, then `load_cfg`, then `incr`.
- R5: `prog_addr` equals the low 10 bits of the pointer, so user addresses above 0x3FF alias.
- R6: `cfg_sel` is 1 only for pointers 0x2000 to 0x200F, and `cfg_idx` is the pointer's low 4 bits. Configuration-half pointers above 0x200F give `cfg_sel`=0 and reach user memory through `prog_addr`.
- R7: `id_hit` is 1 for pointers 0x2000 to 0x2003, and `cfgw_hit` is 1 only for 0x2007.
- R8: `data_addr` equals the low 6 bits of the pointer, so it wraps modulo 64.
- R9: All decode outputs are registered and change on the same clock edge as `addr_q`, one clock after the strobe is sampled.
- R10: With no strobe, `addr_q` and every decode output hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_clr | input | 1 | Synchronous clear on mode entry or exit |
| load_cfg | input | 1 | Jump to configuration base |
| incr | input | 1 | Advance pointer by one |
| addr_q | output | 14 | Current pointer |
| prog_addr | output | 10 | Program memory word address |
| cfg_sel | output | 1 | Configuration store selected |
| cfg_idx | output | 4 | Configuration store word index |
| id_hit | output | 1 | Pointer on an identification word |
| cfgw_hit | output | 1 | Pointer on the configuration word |
| data_addr | output | 6 | Data memory byte address |

## Verification
The hardest state to reach is the wrap from 0x3FFF back to 0x2000. Getting there by counting alone takes more than sixteen thousand increments from user space. The stimulus clears the pointer and applies 16400 consecutive increments. Every step is compared against a reference pointer, which covers the 0x1FFF crossing, the top wrap and the aliasing region just above the configuration window. Strobe collisions and the sticky bit under `load_cfg` are driven as directed cases.

// File: rtl/pacm_pkg.sv
package pacm_pkg;
   typedef enum logic [1:0] {
      PTR_HOLD = 2'd0,
      PTR_STEP = 2'd1,
      PTR_CFG  = 2'd2,
      PTR_ZERO = 2'd3
   } ptr_op_e;
endpackage

// File: rtl/pacm_ptr.sv
module pacm_ptr #(
   parameter int AW = 14
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  pacm_pkg::ptr_op_e    op,
   output logic [AW-1:0]        ptr_q,
   output logic [AW-1:0]        ptr_d
);
   import pacm_pkg::*;

   localparam logic [AW-1:0] CFG_BASE = {1'b1, {(AW-1){1'b0}}};
   localparam logic [AW-1:0] PTR_TOP  = {AW{1'b1}};
   localparam logic [AW-1:0] ONE      = {{(AW-1){1'b0}}, 1'b1};

   logic [AW-1:0] bumped;

   always_comb begin
      bumped = ptr_q + ONE;
      // the upper half is sticky: its top bit never clears on a step
      bumped[AW-1] = bumped[AW-1] | ptr_q[AW-1];
   end

   always_comb begin
      unique case (op)
         PTR_ZERO: ptr_d = '0;
         PTR_CFG:  ptr_d = CFG_BASE;
         PTR_STEP: ptr_d = bumped;
         default:  ptr_d = ptr_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_d;
   end

   p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      op == PTR_ZERO |=> ptr_q == '0);
   p_upper_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op == PTR_STEP && ptr_q == PTR_TOP) |=> ptr_q == CFG_BASE);
   p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_q[AW-1] && op != PTR_ZERO) |=> ptr_q[AW-1]);
   p_cfg_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
      op == PTR_CFG |=> ptr_q == CFG_BASE);
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      op == PTR_HOLD |=> $stable(ptr_q));
endmodule

// File: rtl/pacm_map.sv
module pacm_map #(
   parameter int AW         = 14,
   parameter int USER_AW    = 10,
   parameter int CFG_AW     = 4,
   parameter int DATA_AW    = 6,
   parameter int ID_WORDS   = 4,
   parameter int CFGW_INDEX = 7,
   parameter bit ALIAS_USER = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [AW-1:0]       ptr_d,
   output logic [USER_AW-1:0]  prog_addr,
   output logic                cfg_sel,
   output logic [CFG_AW-1:0]   cfg_idx,
   output logic                id_hit,
   output logic                cfgw_hit,
   output logic [DATA_AW-1:0]  data_addr
);
   localparam logic [CFG_AW-1:0] ID_LIM  = CFG_AW'(ID_WORDS);
   localparam logic [CFG_AW-1:0] CFGW_IX = CFG_AW'(CFGW_INDEX);

   logic in_window, sel_n, id_n, cfgw_n;

   assign in_window = ptr_d[AW-1] && (ptr_d[AW-2:CFG_AW] == '0);

   generate
      if (ALIAS_USER) begin : g_alias
         // past the window, configuration pointers fall through to user store
         assign sel_n = in_window;
      end else begin : g_noalias
         assign sel_n = ptr_d[AW-1];
      end
   endgenerate

   assign id_n   = in_window && (ptr_d[CFG_AW-1:0] < ID_LIM);
   assign cfgw_n = in_window && (ptr_d[CFG_AW-1:0] == CFGW_IX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_addr <= '0;
         cfg_sel   <= 1'b0;
         cfg_idx   <= '0;
         id_hit    <= 1'b0;
         cfgw_hit  <= 1'b0;
         data_addr <= '0;
      end else begin
         prog_addr <= ptr_d[USER_AW-1:0];
         cfg_sel   <= sel_n;
         cfg_idx   <= ptr_d[CFG_AW-1:0];
         id_hit    <= id_n;
         cfgw_hit  <= cfgw_n;
         data_addr <= ptr_d[DATA_AW-1:0];
      end
   end

   p_id_in_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (id_hit || cfgw_hit) |-> cfg_sel);
   p_id_cfgw_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(id_hit && cfgw_hit));
endmodule

// File: rtl/pgm_addr_mapper.sv
module pgm_addr_mapper #(
   parameter int AW         = 14,
   parameter int USER_AW    = 10,
   parameter int CFG_AW     = 4,
   parameter int DATA_AW    = 6,
   parameter int ID_WORDS   = 4,
   parameter int CFGW_INDEX = 7,
   parameter bit ALIAS_USER = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_clr,
   input  logic               load_cfg,
   input  logic               incr,
   output logic [AW-1:0]      addr_q,
   output logic [USER_AW-1:0] prog_addr,
   output logic               cfg_sel,
   output logic [CFG_AW-1:0]  cfg_idx,
   output logic               id_hit,
   output logic               cfgw_hit,
   output logic [DATA_AW-1:0] data_addr
);
   import pacm_pkg::*;

   generate
      if (USER_AW >= AW || DATA_AW >= AW || CFG_AW >= AW - 1) begin : g_bad_width
         $error("pgm_addr_mapper: decode width exceeds pointer width");
      end
      if (ID_WORDS > (1 << CFG_AW) || CFGW_INDEX >= (1 << CFG_AW)) begin : g_bad_cfg
         $error("pgm_addr_mapper: configuration index out of window");
      end
   endgenerate

   ptr_op_e       op;
   logic [AW-1:0] ptr_next;

   always_comb begin
      if (mode_clr)      op = PTR_ZERO;
      else if (load_cfg) op = PTR_CFG;
      else if (incr)     op = PTR_STEP;
      else               op = PTR_HOLD;
   end

   pacm_ptr #(.AW(AW)) i_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .ptr_q (addr_q),
      .ptr_d (ptr_next)
   );

   pacm_map #(
      .AW(AW), .USER_AW(USER_AW), .CFG_AW(CFG_AW), .DATA_AW(DATA_AW),
      .ID_WORDS(ID_WORDS), .CFGW_INDEX(CFGW_INDEX), .ALIAS_USER(ALIAS_USER)
   ) i_map (
      .clk       (clk),
      .rst_n     (rst_n),
      .ptr_d     (ptr_next),
      .prog_addr (prog_addr),
      .cfg_sel   (cfg_sel),
      .cfg_idx   (cfg_idx),
      .id_hit    (id_hit),
      .cfgw_hit  (cfgw_hit),
      .data_addr (data_addr)
   );

   p_map_tracks_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_sel |-> addr_q[AW-1]);
   p_prog_tracks_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      prog_addr == addr_q[USER_AW-1:0]);
   p_data_tracks_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      data_addr == addr_q[DATA_AW-1:0]);
endmodule

// File: tb/test_pgm_addr_mapper.sv
module test_pgm_addr_mapper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_clr = 1'b0, load_cfg = 1'b0, incr = 1'b0;
   logic [13:0] addr_q;
   logic [9:0]  prog_addr;
   logic        cfg_sel, id_hit, cfgw_hit;
   logic [3:0]  cfg_idx;
   logic [5:0]  data_addr;

   int checks = 0, failures = 0;
   bit done = 1'b0;
   logic [13:0] model = '0;

   always #4 clk = ~clk;

   pgm_addr_mapper i_pgm_addr_mapper (
      .clk(clk), .rst_n(rst_n), .mode_clr(mode_clr), .load_cfg(load_cfg),
      .incr(incr), .addr_q(addr_q), .prog_addr(prog_addr), .cfg_sel(cfg_sel),
      .cfg_idx(cfg_idx), .id_hit(id_hit), .cfgw_hit(cfgw_hit),
      .data_addr(data_addr)
   );

   // op codes: 0 none, 1 incr, 2 load_cfg, 3 mode_clr; low 14 bits = expected pointer
   localparam int NV = 14;
   localparam logic [15:0] VEC [NV] = '{
      {2'd1, 14'h0001}, {2'd1, 14'h0002}, {2'd0, 14'h0002}, {2'd2, 14'h2000},
      {2'd1, 14'h2001}, {2'd1, 14'h2002}, {2'd1, 14'h2003}, {2'd1, 14'h2004},
      {2'd0, 14'h2004}, {2'd1, 14'h2005}, {2'd1, 14'h2006}, {2'd1, 14'h2007},
      {2'd1, 14'h2008}, {2'd3, 14'h0000}
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_apply(input logic c, input logic l, input logic i);
      if (c)      model = 14'h0000;
      else if (l) model = 14'h2000;
      else if (i) model = model[13] ? {1'b1, model[12:0] + 13'd1} : model + 14'd1;
   endtask

   task automatic check_all(input string req);
      logic win;
      win = model[13] && (model[12:4] == 9'd0);
      chk(req, "addr_q", int'(addr_q), int'(model));
      chk("R5", "prog_addr", int'(prog_addr), int'(model[9:0]));
      chk("R6", "cfg_sel", int'(cfg_sel), int'(win));
      chk("R6", "cfg_idx", int'(cfg_idx), int'(model[3:0]));
      chk("R7", "id_hit", int'(id_hit), int'(win && model[3:0] < 4'd4));
      chk("R7", "cfgw_hit", int'(cfgw_hit), int'(win && model[3:0] == 4'd7));
      chk("R8", "data_addr", int'(data_addr), int'(model[5:0]));
   endtask

   // strobes set at a falling edge, sampled at the rising edge, outputs checked at the next falling edge (R9)
   task automatic step(input logic c, input logic l, input logic i, input string req);
      @(negedge clk);
      mode_clr = c; load_cfg = l; incr = i;
      @(negedge clk);
      mode_clr = 1'b0; load_cfg = 1'b0; incr = 1'b0;
      model_apply(c, l, i);
      check_all(req);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_all("R1");                       // R1: reset state
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R2, R4, R6, R7, R10
      for (int k = 0; k < NV; k++) begin
         step(VEC[k][15:14] == 2'd3, VEC[k][15:14] == 2'd2, VEC[k][15:14] == 2'd1, "R2/R4/R10");
         chk("R9", "vector pointer", int'(addr_q), int'(VEC[k][13:0]));
      end

      // R4 priority: load_cfg beats incr, mode_clr beats both
      step(1'b0, 1'b1, 1'b1, "R4");
      step(1'b1, 1'b1, 1'b1, "R4");
      // R3: load_cfg inside the upper half keeps bit 13
      step(1'b0, 1'b1, 1'b0, "R4");
      step(1'b0, 1'b1, 1'b0, "R3");
      step(1'b1, 1'b0, 1'b0, "R1");

      // long sweep through the 0x1FFF crossing, the top wrap and the alias region (R2, R3, R5, R6, R8)
      for (int k = 0; k < 16400; k++) begin
         step(1'b0, 1'b0, 1'b1, (model == 14'h3FFF) ? "R3" : "R2");
      end
      chk("R3", "after sweep", int'(addr_q), 32'h2010);
      chk("R6", "alias cfg_sel", int'(cfg_sel), 0);
      chk("R5", "alias prog_addr", int'(prog_addr), 32'h010);

      // R10: idle cycles hold everything
      for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b0, "R10");
      // R1: clear exits configuration space
      step(1'b1, 1'b0, 1'b0, "R1");
      chk("R1", "cleared", int'(addr_q), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule